// File: doc/BRIEF.md
# Windowed Display-Memory Address Pointer

This block sits between a byte-wide host link and a frame memory of a small gray-scale panel controller. The host sends a stream of bytes, each marked as either a command or display data. Command sequences define a rectangular window of columns and rows and choose which axis the pointer advances along. Each display-data byte is presented to the frame memory with a write enable, together with the current column and row. The pointer then moves to the next cell in the window.

Column addresses select a byte that holds two 4-bit pixels. Column and row addresses both run from 0 to 63. When the pointer reaches the end of the window on its primary axis, it returns to the start of that axis and carries one step into the other axis. When both axes reach their ends at the same write, both return to their starts. The block does not model panel scanning, gray levels, analog settings or read-back. Other commands are recognised only far enough to skip their parameter bytes.

Top module: `windowed_ram_ptr`

## Requirements
- R1: After reset, col and row are 0, both windows span 0 to 63, the pointer advances horizontally, and mem_we is low.
- R2: Three command bytes 0x15, s, e set the column window to s[5:0] .. e[5:0] and place col at s[5:0]. row is unchanged.
- R3: Three command bytes 0x75, s, e set the row window to s[5:0] .. e[5:0] and place row at s[5:0]. col is unchanged.
- R4: In the cycle where wr_stb=1 and is_data=1, mem_we is 1, mem_wdata equals bus_byte, and col/row give the address of that write. mem_we is 0 in every other cycle.
- R5: In horizontal mode, a data write below the column end increments col by one and leaves row unchanged.
- R6: In horizontal mode, a data write at the column end sets col to the column start and increments row. If row is also at the row end, row returns to the row start.
- R7: Command 0xA0 followed by a parameter with bit 2 set selects vertical mode. In vertical mode, row increments on each data write. At the row end, row returns to the row start and col advances, wrapping to the column start at the column end.
- R8: Command 0xA0 followed by a parameter with bit 2 clear selects horizontal mode again.
- R9: Other command bytes change neither window nor pointer, and their parameter bytes are skipped. 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB0-0xB4, 0xBC, 0xBE and 0xBF take one parameter, 0xB8 takes eight, and all others take none. A skipped parameter equal to 0x15 or 0x75 starts nothing.
- R10: In a cycle with wr_stb=0, col, row and the windows do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_byte | input | 8 | Command or data byte from the host |
| is_data | input | 1 | 1 = display data, 0 = command or parameter |
| wr_stb | input | 1 | Byte is valid this cycle |
| col | output | 6 | Current column pointer (byte of two pixels) |
| row | output | 6 | Current row pointer |
| mem_we | output | 1 | Frame-memory write enable |
| mem_wdata | output | 8 | Frame-memory write data |

## Verification
A pointer that steps wrongly, wraps at the wrong bound or fails to carry into the other axis puts a data byte at the wrong col/row. This shows up in the very next data-write cycle, so every expected write is queued with its address and compared when mem_we rises. A parameter counter that loses count misreads a later parameter as a command. Its window or mode change then shows only at the first data write that follows. For that reason, each skipped-command sequence is followed at once by data writes and by idle cycles that compare col and row.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int PCNT_W = 4;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_COL   = 2'd1,
    K_ROW   = 2'd2,
    K_REMAP = 2'd3
  } cmd_kind_e;

  localparam logic [7:0] OP_COL_WIN = 8'h15;
  localparam logic [7:0] OP_ROW_WIN = 8'h75;
  localparam logic [7:0] OP_REMAP   = 8'hA0;

  // number of parameter bytes that follow a command opcode
  function automatic logic [PCNT_W-1:0] param_count(input logic [7:0] op);
    logic [PCNT_W-1:0] n;
    case (op)
      OP_COL_WIN, OP_ROW_WIN:             n = 4'd2;
      OP_REMAP:                           n = 4'd1;
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD:  n = 4'd1;
      8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4:  n = 4'd1;
      8'hBC, 8'hBE, 8'hBF:                n = 4'd1;
      8'hB8:                              n = 4'd8;
      default:                            n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic cmd_kind_e kind_of(input logic [7:0] op);
    cmd_kind_e k;
    case (op)
      OP_COL_WIN: k = K_COL;
      OP_ROW_WIN: k = K_ROW;
      OP_REMAP:   k = K_REMAP;
      default:    k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
#(
  parameter int AW = 6,
  parameter int VERT_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    bus_byte,
  input  logic          is_data,
  input  logic          wr_stb,
  output logic          col_load,
  output logic          row_load,
  output logic [AW-1:0] load_start,
  output logic [AW-1:0] load_end,
  output logic          vert_mode
);

  cmd_kind_e         kind_q, kind_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [AW-1:0]     first_q, first_d;
  logic              vert_q, vert_d;
  logic              cmd_wr;
  logic              first_en;

  assign cmd_wr = wr_stb & ~is_data;

  always_comb begin
    kind_d   = kind_q;
    pcnt_d   = pcnt_q;
    first_d  = first_q;
    vert_d   = vert_q;
    col_load = 1'b0;
    row_load = 1'b0;
    first_en = 1'b0;
    if (cmd_wr) begin
      if (pcnt_q == '0) begin
        kind_d = kind_of(bus_byte);
        pcnt_d = param_count(bus_byte);
      end else begin
        pcnt_d = pcnt_q - 1'b1;
        if (pcnt_q == PCNT_W'(2) && (kind_q == K_COL || kind_q == K_ROW)) begin
          first_en = 1'b1;
        end
        if (pcnt_q == PCNT_W'(1)) begin
          kind_d = K_NONE;
          case (kind_q)
            K_COL:   col_load = 1'b1;
            K_ROW:   row_load = 1'b1;
            K_REMAP: vert_d   = bus_byte[VERT_BIT];
            default: ;
          endcase
        end
      end
    end
    if (first_en) first_d = bus_byte[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_NONE;
      pcnt_q  <= '0;
      first_q <= '0;
      vert_q  <= 1'b0;
    end else if (cmd_wr) begin
      kind_q  <= kind_d;
      pcnt_q  <= pcnt_d;
      first_q <= first_d;
      vert_q  <= vert_d;
    end
  end

  assign load_start = first_q;
  assign load_end   = bus_byte[AW-1:0];
  assign vert_mode  = vert_q;

  // R9: each parameter byte consumes exactly one count
  a_r9_param_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && pcnt_q != '0) |=> (pcnt_q == $past(pcnt_q) - 1'b1));

  // R4: a data byte leaves the command state untouched
  a_r4_data_no_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && is_data) |=> ($stable(pcnt_q) && $stable(vert_q)));

  // R2/R3: at most one window load per cycle
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({col_load, row_load}));

endmodule

// File: rtl/wp_axis_step.sv
module wp_axis_step #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] nxt,
  output logic          wrap
);

  always_comb begin
    wrap = (cur == hi);
    nxt  = wrap ? lo : cur + 1'b1;
  end

endmodule

// File: rtl/wp_pointer.sv
module wp_pointer #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic          vert_mode,
  input  logic          col_load,
  input  logic          row_load,
  input  logic [AW-1:0] load_start,
  input  logic [AW-1:0] load_end,
  output logic [AW-1:0] col,
  output logic [AW-1:0] row
);

  localparam int NAX = 2;           // axis 0 = column, axis 1 = row
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic [AW-1:0] ptr_q [NAX];
  logic [AW-1:0] ptr_d [NAX];
  logic [AW-1:0] lo_q  [NAX];
  logic [AW-1:0] lo_d  [NAX];
  logic [AW-1:0] hi_q  [NAX];
  logic [AW-1:0] hi_d  [NAX];
  logic [AW-1:0] step  [NAX];
  logic          wrap  [NAX];
  logic [NAX-1:0] load;
  logic           upd_en;

  assign load = {row_load, col_load};

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    wp_axis_step #(.AW(AW)) u_step (
      .cur  (ptr_q[a]),
      .lo   (lo_q[a]),
      .hi   (hi_q[a]),
      .nxt  (step[a]),
      .wrap (wrap[a])
    );
  end

  always_comb begin
    for (int a = 0; a < NAX; a++) begin
      ptr_d[a] = ptr_q[a];
      lo_d[a]  = lo_q[a];
      hi_d[a]  = hi_q[a];
      if (load[a]) begin
        lo_d[a]  = load_start;
        hi_d[a]  = load_end;
        ptr_d[a] = load_start;
      end
    end
    if (data_we) begin
      if (!vert_mode) begin
        ptr_d[0] = step[0];
        if (wrap[0]) ptr_d[1] = step[1];
      end else begin
        ptr_d[1] = step[1];
        if (wrap[1]) ptr_d[0] = step[0];
      end
    end
  end

  assign upd_en = data_we | (|load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NAX; a++) begin
        ptr_q[a] <= '0;
        lo_q[a]  <= '0;
        hi_q[a]  <= TOP;
      end
    end else if (upd_en) begin
      for (int a = 0; a < NAX; a++) begin
        ptr_q[a] <= ptr_d[a];
        lo_q[a]  <= lo_d[a];
        hi_q[a]  <= hi_d[a];
      end
    end
  end

  assign col = ptr_q[0];
  assign row = ptr_q[1];

  // R2: a column window load places the column pointer at its start
  a_r2_col_load: assert property (@(posedge clk) disable iff (!rst_n)
    col_load |=> (col == $past(load_start)) && $stable(row));

  // R3: a row window load places the row pointer at its start
  a_r3_row_load: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |=> (row == $past(load_start)) && $stable(col));

  // R5: horizontal step inside the window
  a_r5_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !vert_mode && col != hi_q[0]) |=>
      (col == $past(col) + 1'b1) && $stable(row));

  // R6: horizontal wrap carries into the row
  a_r6_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !vert_mode && col == hi_q[0] && row != hi_q[1]) |=>
      (col == $past(lo_q[0])) && (row == $past(row) + 1'b1));

  // R7: vertical step inside the window
  a_r7_v_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && vert_mode && row != hi_q[1]) |=>
      (row == $past(row) + 1'b1) && $stable(col));

  // R10: nothing moves without a write or a load
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_we && load == '0) |=> ($stable(col) && $stable(row)));

endmodule

// File: rtl/windowed_ram_ptr.sv
module windowed_ram_ptr #(
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_byte,
  input  logic              is_data,
  input  logic              wr_stb,
  output logic [ADDR_W-1:0] col,
  output logic [ADDR_W-1:0] row,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ok;
  logic                   wr_ok;
  logic                   col_load, row_load, vert_mode;
  logic [ADDR_W-1:0]      load_start, load_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ok = rst_pipe[SYNC_STAGES-1];

  assign wr_ok = wr_stb & rst_ok;

  wp_cmd_decode #(.AW(ADDR_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_ok),
    .bus_byte   (bus_byte),
    .is_data    (is_data),
    .wr_stb     (wr_ok),
    .col_load   (col_load),
    .row_load   (row_load),
    .load_start (load_start),
    .load_end   (load_end),
    .vert_mode  (vert_mode)
  );

  assign mem_we    = wr_ok & is_data;
  assign mem_wdata = bus_byte;

  wp_pointer #(.AW(ADDR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_ok),
    .data_we    (mem_we),
    .vert_mode  (vert_mode),
    .col_load   (col_load),
    .row_load   (row_load),
    .load_start (load_start),
    .load_end   (load_end),
    .col        (col),
    .row        (row)
  );

  // R4: write enable only for strobed data bytes
  a_r4_we_qual: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_stb && is_data));

endmodule

// File: tb/windowed_ram_ptr_test.sv
`timescale 1ns/1ps
module windowed_ram_ptr_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_byte;
  logic       is_data;
  logic       wr_stb;
  logic [5:0] col, row;
  logic       mem_we;
  logic [7:0] mem_wdata;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  logic [19:0] expq [$];

  // independent model of the pointer
  logic [5:0] mc, mr, cs, ce, rs, re;
  logic       mv;

  always #10 clk = ~clk;

  windowed_ram_ptr uut (
    .clk(clk), .rst_n(rst_n), .bus_byte(bus_byte), .is_data(is_data),
    .wr_stb(wr_stb), .col(col), .row(row), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic d, input logic [7:0] b);
    @(posedge clk); #2;
    is_data = d; bus_byte = b; wr_stb = 1'b1;
    @(posedge clk); #2;
    wr_stb = 1'b0; is_data = 1'b0;
  endtask

  task automatic set_col(input logic [7:0] s, input logic [7:0] e);
    put(0, 8'h15); put(0, s); put(0, e);
    cs = s[5:0]; ce = e[5:0]; mc = s[5:0];
  endtask

  task automatic set_row(input logic [7:0] s, input logic [7:0] e);
    put(0, 8'h75); put(0, s); put(0, e);
    rs = s[5:0]; re = e[5:0]; mr = s[5:0];
  endtask

  task automatic set_mode(input logic [7:0] p);
    put(0, 8'hA0); put(0, p);
    mv = p[2];
  endtask

  task automatic wr_data(input logic [7:0] b);
    expq.push_back({mc, mr, b});
    if (!mv) begin
      if (mc == ce) begin mc = cs; mr = (mr == re) ? rs : mr + 6'd1; end
      else mc = mc + 6'd1;
    end else begin
      if (mr == re) begin mr = rs; mc = (mc == ce) ? cs : mc + 6'd1; end
      else mr = mr + 6'd1;
    end
    put(1, b);
  endtask

  task automatic idle_check(input string req);
    @(posedge clk); @(negedge clk);
    chk(req, {26'd0, col}, {26'd0, mc});
    chk(req, {26'd0, row}, {26'd0, mr});
    chk(req, {31'd0, mem_we}, 32'd0);
  endtask

  // monitor: compare each memory write with the queued expectation
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (expq.size() == 0) begin
        chk("R4 unexpected write", {12'd0, col, row, mem_wdata}, 32'hFFFFF);
      end else begin
        logic [19:0] e;
        e = expq.pop_front();
        chk("R4-R7 write address/data", {12'd0, col, row, mem_wdata}, {12'd0, e});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nvec++; nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_byte = '0; is_data = 1'b0; wr_stb = 1'b0;
    mc = 0; mr = 0; cs = 0; ce = 63; rs = 0; re = 63; mv = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: reset state
    idle_check("R1 reset pointer");
    // R1: full windows, horizontal: writes walk along the columns
    for (int i = 0; i < 3; i++) wr_data(8'h10 + 8'(i));
    idle_check("R5 after full-window writes");
    // R2 with bytes above 63 (low six bits used), R3
    set_col(8'h42, 8'h44);
    idle_check("R2 column window");
    set_row(8'h0A, 8'h0B);
    idle_check("R3 row window");
    // R5/R6: 3x2 window, seven writes include the double wrap
    for (int i = 0; i < 7; i++) wr_data(8'hA0 + 8'(i));
    idle_check("R6 double wrap");
    // R10: idle cycles change nothing
    repeat (5) @(posedge clk);
    idle_check("R10 hold");
    // R9: skipped parameters that look like window commands
    put(0, 8'h81); put(0, 8'h15); put(0, 8'h20); put(0, 8'h30);
    idle_check("R9 one-parameter skip");
    put(0, 8'hB8);
    put(0, 8'h75); put(0, 8'h05); put(0, 8'h06); put(0, 8'h15);
    put(0, 8'h01); put(0, 8'h02); put(0, 8'hA0); put(0, 8'h04);
    put(0, 8'hA4);
    idle_check("R9 eight-parameter skip");
    for (int i = 0; i < 4; i++) wr_data(8'h30 + 8'(i));
    // R7: vertical mode, wraps carrying into columns and both axes
    set_col(8'd61, 8'd63);
    set_row(8'd0, 8'd2);
    set_mode(8'h04);
    for (int i = 0; i < 10; i++) wr_data(8'h50 + 8'(i));
    idle_check("R7 vertical wrap");
    // R8: back to horizontal
    set_mode(8'h41);
    for (int i = 0; i < 5; i++) wr_data(8'h70 + 8'(i));
    idle_check("R8 horizontal again");
    repeat (3) @(posedge clk);
    chk("R4 all writes seen", expq.size(), 32'd0);
    finish_run();
  end

endmodule